// File: doc/BRIEF.md
# Packing byte FIFO pair for a serial peripheral

This block holds the data that flows between a register bus and a serial shift engine. It has one four-byte queue for each direction. The bus side writes the transmit queue and reads the receive queue, using either single-byte or two-byte accesses. The engine side takes frames from the transmit queue and delivers frames into the receive queue. Occupancy is counted in bytes, not in frames.

When frames are eight bits or shorter, one two-byte access carries two frames, and the first frame sits in the low byte. Wider frames always take two bytes. The block raises two events:
- A transmit-space event, when at least two bytes are free.
- A receive-ready event, when the held bytes reach a selectable threshold of one byte or two bytes.

Both events are also presented as DMA request lines. A frame that arrives from the engine when the receive queue has no room is discarded, and a sticky overrun flag is set.

Top module: `spi_pack_fifo`

## Requirements
- R1: After reset both queues are empty, `tx_empty` and `tx_dma_req` are 1, and `rx_ready`, `rx_dma_req`, `rx_overrun` and `eng_tx_valid` are 0.
- R2: A bus write with `bus_wr_half`=0 queues byte `bus_wdata[7:0]`, and one with `bus_wr_half`=1 queues two bytes. With `frame_wide`=0, a two-byte write is two frames, and the engine sees `bus_wdata[7:0]` first, then `bus_wdata[15:8]`, each on `eng_tx_frame[7:0]`.
- R3: With `frame_wide`=1, one engine pop removes two bytes, and `eng_tx_frame` shows {second byte, first byte}. Two single-byte writes therefore form one frame, with the first write in bits [7:0].
- R4: `tx_empty` is 1 exactly when the transmit queue has two or more free bytes. After three bytes have been written it is 0, even though one byte is still free.
- R5: A bus write that needs more bytes than are free is dropped as a whole, and the queued contents stay as they were.
- R6: With `frame_wide`=0, two received frames are returned by one two-byte read, with the earlier frame in `bus_rdata[7:0]`. `bus_rdata` always shows the oldest receive byte in [7:0] and the next byte in [15:8].
- R7: `rx_ready` is 1 when the receive queue holds at least one byte if `rx_quarter`=1, or at least two bytes if `rx_quarter`=0.
- R8: An engine frame (one byte if `frame_wide`=0, two if 1) that finds too little receive space is discarded, and `rx_overrun` goes to 1 and stays at 1 until reset.
- R9: `tx_dma_req` equals `tx_empty`, and `rx_dma_req` equals `rx_ready`.
- R10: A bus read of more bytes than the receive queue holds removes nothing.
- R11: `eng_tx_valid` is 1 when the transmit queue holds at least one frame's worth of bytes (1 if `frame_wide`=0, 2 if 1). An engine pop while it is 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_wide | input | 1 | 1: frames longer than 8 bits (two bytes each) |
| rx_quarter | input | 1 | 1: receive threshold of one byte; 0: two bytes |
| bus_wr | input | 1 | Bus write strobe to the transmit queue |
| bus_wr_half | input | 1 | 1: two-byte write; 0: one byte |
| bus_wdata | input | 16 | Bus write data |
| bus_rd | input | 1 | Bus read strobe from the receive queue |
| bus_rd_half | input | 1 | 1: two-byte read; 0: one byte |
| bus_rdata | output | 16 | Oldest two receive bytes, oldest in the low byte |
| eng_tx_pop | input | 1 | Engine takes one transmit frame |
| eng_tx_frame | output | 16 | Transmit frame at the head of the queue |
| eng_tx_valid | output | 1 | A full transmit frame is available |
| eng_rx_push | input | 1 | Engine delivers one received frame |
| eng_rx_frame | input | 16 | Received frame data |
| tx_empty | output | 1 | Transmit space event |
| rx_ready | output | 1 | Receive threshold event |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |
| rx_overrun | output | 1 | Sticky receive overrun flag |

## Verification
The queue state is updated at the rising edge that accepts a write, read, push or pop. Every result is decoded combinationally from that state: the events, `eng_tx_valid`, `eng_tx_frame`, `bus_rdata` and `rx_overrun`. So each result is due one edge after its stimulus. The bench applies each strobe at a falling edge, removes it at the next falling edge, and samples there, which is after exactly one rising edge. Head data is read before a pop or read is issued.

// File: rtl/spi_pack_pkg.sv
package spi_pack_pkg;
    typedef enum logic {
        SZ_BYTE = 1'b0,
        SZ_HALF = 1'b1
    } xfer_sz_e;

    function automatic int unsigned sz_bytes(input xfer_sz_e sz);
        return (sz == SZ_HALF) ? 2 : 1;
    endfunction
endpackage

// File: rtl/spi_pack_bytefifo.sv
module spi_pack_bytefifo
    import spi_pack_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int DEPTH  = 4,
    localparam int PW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_en,
    input  logic              push_two,
    input  logic [2*BYTE_W-1:0] push_data,
    input  logic              pop_en,
    input  logic              pop_two,
    output logic [2*BYTE_W-1:0] head_data,
    output logic [CW-1:0]     count,
    output logic              push_ok,
    output logic              pop_ok
);
    typedef struct packed {
        logic [DEPTH-1:0][BYTE_W-1:0] mem;
        logic [PW-1:0]                wp;
        logic [PW-1:0]                rp;
        logic [CW-1:0]                cnt;
    } st_t;

    st_t st_d, st_q;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        if (p == PW'(DEPTH - 1)) return '0;
        return p + 1'b1;
    endfunction

    logic [CW-1:0] push_n, pop_n, free_n;

    always_comb begin
        push_n  = CW'(sz_bytes(xfer_sz_e'(push_two)));
        pop_n   = CW'(sz_bytes(xfer_sz_e'(pop_two)));
        free_n  = CW'(DEPTH) - st_q.cnt;
        push_ok = push_en && (free_n >= push_n);
        pop_ok  = pop_en && (st_q.cnt >= pop_n);
        st_d    = st_q;
        if (push_ok) begin
            st_d.mem[st_q.wp] = push_data[BYTE_W-1:0];
            if (push_two) begin
                st_d.mem[step(st_q.wp)] = push_data[2*BYTE_W-1:BYTE_W];
                st_d.wp = step(step(st_q.wp));
            end else begin
                st_d.wp = step(st_q.wp);
            end
        end
        if (pop_ok) begin
            st_d.rp = pop_two ? step(step(st_q.rp)) : step(st_q.rp);
        end
        st_d.cnt = st_q.cnt + (push_ok ? push_n : '0) - (pop_ok ? pop_n : '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head_data = {st_q.mem[step(st_q.rp)], st_q.mem[st_q.rp]};
    assign count     = st_q.cnt;

    assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    assert_drop_keeps_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && !push_ok && !pop_ok) |=> count == $past(count));
    assert_short_pop_keeps_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_en && !pop_ok && !push_ok) |=> count == $past(count));
    assert_two_byte_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok && push_two && !pop_ok) |=> count == $past(count) + CW'(2));
endmodule

// File: rtl/spi_pack_flags.sv
module spi_pack_flags #(
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] tx_count,
    input  logic [CW-1:0] rx_count,
    input  logic          rx_quarter,
    input  logic          rx_push,
    input  logic          rx_push_ok,
    output logic          tx_empty,
    output logic          rx_ready,
    output logic          overrun
);
    typedef struct packed {
        logic ovr;
    } st_t;

    st_t st_d, st_q;
    logic [CW-1:0] rx_level;

    always_comb begin
        st_d     = st_q;
        if (rx_push && !rx_push_ok) st_d.ovr = 1'b1;
        rx_level = rx_quarter ? CW'(1) : CW'(2);
        tx_empty = (CW'(DEPTH) - tx_count) >= CW'(2);
        rx_ready = rx_count >= rx_level;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign overrun = st_q.ovr;

    assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
    assert_overrun_on_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && !rx_push_ok) |=> overrun);
endmodule

// File: rtl/spi_pack_fifo.sv
module spi_pack_fifo #(
    parameter int BYTE_W     = 8,
    parameter int FIFO_BYTES = 4,
    localparam int DW        = 2 * BYTE_W,
    localparam int CW        = $clog2(FIFO_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_wide,
    input  logic          rx_quarter,
    input  logic          bus_wr,
    input  logic          bus_wr_half,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_rd,
    input  logic          bus_rd_half,
    output logic [DW-1:0] bus_rdata,
    input  logic          eng_tx_pop,
    output logic [DW-1:0] eng_tx_frame,
    output logic          eng_tx_valid,
    input  logic          eng_rx_push,
    input  logic [DW-1:0] eng_rx_frame,
    output logic          tx_empty,
    output logic          rx_ready,
    output logic          tx_dma_req,
    output logic          rx_dma_req,
    output logic          rx_overrun
);
    logic [CW-1:0] tx_count, rx_count;
    logic tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok;

    spi_pack_bytefifo #(.BYTE_W(BYTE_W), .DEPTH(FIFO_BYTES)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push_en(bus_wr), .push_two(bus_wr_half), .push_data(bus_wdata),
        .pop_en(eng_tx_pop), .pop_two(frame_wide),
        .head_data(eng_tx_frame), .count(tx_count),
        .push_ok(tx_push_ok), .pop_ok(tx_pop_ok)
    );

    spi_pack_bytefifo #(.BYTE_W(BYTE_W), .DEPTH(FIFO_BYTES)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push_en(eng_rx_push), .push_two(frame_wide), .push_data(eng_rx_frame),
        .pop_en(bus_rd), .pop_two(bus_rd_half),
        .head_data(bus_rdata), .count(rx_count),
        .push_ok(rx_push_ok), .pop_ok(rx_pop_ok)
    );

    spi_pack_flags #(.DEPTH(FIFO_BYTES)) u_flags (
        .clk(clk), .rst_n(rst_n),
        .tx_count(tx_count), .rx_count(rx_count), .rx_quarter(rx_quarter),
        .rx_push(eng_rx_push), .rx_push_ok(rx_push_ok),
        .tx_empty(tx_empty), .rx_ready(rx_ready), .overrun(rx_overrun)
    );

    assign eng_tx_valid = tx_count >= (frame_wide ? CW'(2) : CW'(1));
    assign tx_dma_req   = tx_empty;
    assign rx_dma_req   = rx_ready;

    assert_pop_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_tx_pop && !eng_tx_valid) |-> !tx_pop_ok);
    assert_write_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && tx_push_ok && !tx_pop_ok) |=> tx_count > $past(tx_count));
    assert_short_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !rx_pop_ok && !eng_rx_push) |=> rx_count == $past(rx_count));
endmodule

// File: tb/spi_pack_fifo_test.sv
module spi_pack_fifo_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_wide = 1'b0, rx_quarter = 1'b0;
    logic bus_wr = 1'b0, bus_wr_half = 1'b0, bus_rd = 1'b0, bus_rd_half = 1'b0;
    logic eng_tx_pop = 1'b0, eng_rx_push = 1'b0;
    logic [15:0] bus_wdata = '0, eng_rx_frame = '0;
    logic [15:0] bus_rdata, eng_tx_frame;
    logic eng_tx_valid, tx_empty, rx_ready, tx_dma_req, rx_dma_req, rx_overrun;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    spi_pack_fifo uut (
        .clk(clk), .rst_n(rst_n), .frame_wide(frame_wide), .rx_quarter(rx_quarter),
        .bus_wr(bus_wr), .bus_wr_half(bus_wr_half), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_rd_half(bus_rd_half), .bus_rdata(bus_rdata),
        .eng_tx_pop(eng_tx_pop), .eng_tx_frame(eng_tx_frame), .eng_tx_valid(eng_tx_valid),
        .eng_rx_push(eng_rx_push), .eng_rx_frame(eng_rx_frame),
        .tx_empty(tx_empty), .rx_ready(rx_ready), .tx_dma_req(tx_dma_req),
        .rx_dma_req(rx_dma_req), .rx_overrun(rx_overrun)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic half, input logic [15:0] d);
        bus_wr = 1'b1; bus_wr_half = half; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic half);
        bus_rd = 1'b1; bus_rd_half = half;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pop();
        eng_tx_pop = 1'b1;
        @(negedge clk);
        eng_tx_pop = 1'b0;
    endtask

    task automatic push(input logic [15:0] d);
        eng_rx_push = 1'b1; eng_rx_frame = d;
        @(negedge clk);
        eng_rx_push = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 tx_empty", 16'(tx_empty), 16'd1);
        chk("R1 rx_ready", 16'(rx_ready), 16'd0);
        chk("R1 overrun", 16'(rx_overrun), 16'd0);
        chk("R1 tx_valid", 16'(eng_tx_valid), 16'd0);
        chk("R1 R9 tx_dma", 16'(tx_dma_req), 16'd1);
        chk("R1 R9 rx_dma", 16'(rx_dma_req), 16'd0);
    endtask

    task automatic t_tx_pack();
        frame_wide = 1'b0;
        wr(1'b1, 16'hB2A1);
        chk("R2 valid", 16'(eng_tx_valid), 16'd1);
        chk("R2 first frame", 16'(eng_tx_frame[7:0]), 16'h00A1);
        chk("R4 two free", 16'(tx_empty), 16'd1);
        pop();
        chk("R2 second frame", 16'(eng_tx_frame[7:0]), 16'h00B2);
        pop();
        chk("R11 drained", 16'(eng_tx_valid), 16'd0);
        pop();
        chk("R11 empty pop", 16'(eng_tx_valid), 16'd0);
    endtask

    task automatic t_tx_level();
        frame_wide = 1'b0;
        wr(1'b1, 16'h2211);
        wr(1'b0, 16'h0033);
        chk("R4 three bytes", 16'(tx_empty), 16'd0);
        chk("R9 tx_dma", 16'(tx_dma_req), 16'd0);
        wr(1'b0, 16'h0044);
        wr(1'b0, 16'h0055);
        wr(1'b1, 16'h6666);
        for (int i = 0; i < 4; i++) begin
            chk("R5 content", 16'(eng_tx_frame[7:0]), 16'(8'h11 * (i + 1)));
            pop();
        end
        chk("R5 nothing extra", 16'(eng_tx_valid), 16'd0);
        wr(1'b1, 16'h9988);
        wr(1'b1, 16'hBBAA);
        wr(1'b1, 16'hDDCC);
        chk("R5 full", 16'(eng_tx_frame[7:0]), 16'h0088);
        for (int i = 0; i < 4; i++) pop();
        chk("R5 half dropped", 16'(eng_tx_valid), 16'd0);
    endtask

    task automatic t_tx_wide();
        frame_wide = 1'b1;
        wr(1'b1, 16'hBEEF);
        wr(1'b1, 16'h1234);
        chk("R4 full", 16'(tx_empty), 16'd0);
        chk("R3 frame one", eng_tx_frame, 16'hBEEF);
        pop();
        chk("R3 frame two", eng_tx_frame, 16'h1234);
        pop();
        wr(1'b0, 16'h0077);
        chk("R11 one byte wide", 16'(eng_tx_valid), 16'd0);
        wr(1'b0, 16'h0066);
        chk("R11 two bytes wide", 16'(eng_tx_valid), 16'd1);
        chk("R3 byte pair", eng_tx_frame, 16'h6677);
        pop();
        chk("R3 drained", 16'(eng_tx_valid), 16'd0);
    endtask

    task automatic t_rx();
        frame_wide = 1'b0; rx_quarter = 1'b0;
        push(16'h005A);
        chk("R7 one below half", 16'(rx_ready), 16'd0);
        push(16'h00A5);
        chk("R7 half reached", 16'(rx_ready), 16'd1);
        chk("R9 rx_dma", 16'(rx_dma_req), 16'd1);
        chk("R6 packed read", bus_rdata, 16'hA55A);
        rd(1'b1);
        chk("R6 read drained", 16'(rx_ready), 16'd0);
        rx_quarter = 1'b1;
        push(16'h003C);
        chk("R7 quarter", 16'(rx_ready), 16'd1);
        rd(1'b1);
        chk("R10 short read", 16'(rx_ready), 16'd1);
        chk("R10 data kept", 16'(bus_rdata[7:0]), 16'h003C);
        rd(1'b0);
        chk("R6 byte read", 16'(rx_ready), 16'd0);
    endtask

    task automatic t_overrun();
        frame_wide = 1'b1; rx_quarter = 1'b0;
        push(16'h1111);
        push(16'h2222);
        chk("R8 no overrun yet", 16'(rx_overrun), 16'd0);
        push(16'h3333);
        chk("R8 overrun", 16'(rx_overrun), 16'd1);
        chk("R8 oldest", bus_rdata, 16'h1111);
        rd(1'b1);
        chk("R8 next", bus_rdata, 16'h2222);
        rd(1'b1);
        chk("R8 dropped frame", 16'(rx_ready), 16'd0);
        chk("R8 sticky", 16'(rx_overrun), 16'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_tx_pack();
        t_tx_level();
        t_tx_wide();
        t_rx();
        t_overrun();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule